// File: doc/BRIEF.md
# Skip-Cluster Rate Match FIFO

This block is an elastic buffer between a receive clock recovered from a serial link and a local clock that runs at nearly the same rate. Decoded 8b/10b characters go in on the receive side. Each character is an 8-bit value with a control flag. The same characters come out on the local side in the same order. Over time the two clocks drift apart, and the buffer makes up the difference. It does this only inside skip clusters: a comma control character (K28.5, value 0xBC with the control flag set) followed directly by one or more skip control characters (K29.7, value 0xFD with the control flag set).

When the local side reads the buffer close to empty, the block gains one character by sending a cluster skip twice. When the receive side fills the buffer close to full, the block loses one character by not storing a cluster skip. Data characters and commas always pass through unchanged. A full flag is given in the write domain and an empty flag in the read domain.

Top module: `skip_rate_fifo`

## Requirements
- R1: A skip (control flag 1, value 0xFD) belongs to a cluster only if it follows a comma (control flag 1, value 0xBC) or another skip of that same cluster with nothing in between. A skip outside a cluster is never added and never removed.
- R2: A cluster skip reaches the read head while read-side occupancy is below DEPTH/4 (4 with the defaults). In that case the skip is sent twice and the read position does not advance on the first send. This happens at most once per cluster, however many skips the cluster holds.
- R3: Insertion is decided per cluster. A cluster of three skips and a later cluster of two skips, each read at low occupancy, each gain exactly one skip.
- R4: A cluster skip arrives while write-side occupancy is above 3*DEPTH/4 (12 with the defaults), and the cluster already has one stored skip. In that case the skip is not stored. This happens at most once per cluster. The first skip of a cluster and the comma are always stored.
- R5: Data characters (control flag 0) and commas come out in order, unmodified, exactly once.
- R6: `full` is high when DEPTH characters are held. A write presented while `full` is high is dropped, and the write position does not move.
- R7: `empty` is high when no stored character is available. A read request while `empty` is high leaves `rd_valid` low and `rd_ctrl`/`rd_data` at their previous values.
- R8: While the resets are high, `empty` is 1, `full` is 0 and `rd_valid` is 0, and both pointers and the cluster tracking are cleared.
- R9: When occupancy stays between the two thresholds, a cluster passes through with no skip added or removed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | A character is presented this cycle |
| wr_ctrl | input | 1 | Control flag of the written character |
| wr_data | input | 8 | Value of the written character |
| full | output | 1 | Buffer holds DEPTH characters |
| rd_clk | input | 1 | Local fabric clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request |
| rd_valid | output | 1 | A character was delivered this cycle |
| rd_ctrl | output | 1 | Control flag of the delivered character |
| rd_data | output | 8 | Value of the delivered character |
| empty | output | 1 | No stored character is available |

## Verification
Some properties hold on every cycle and are checked by the bound checker. A dropped write never moves the write pointer. Each pointer moves by at most one per cycle. A request while empty produces no output and keeps the held character. Any delivered data character or comma always advances the read pointer, so only skips can ever be replayed. Other behaviour depends on the order of the whole stream, and only the bench's scenarios show it. That covers which skip is added or removed, that each cluster changes by exactly one character, that lone skips are left alone, and that a cluster between the thresholds stays intact. The bench does this by comparing the complete delivered stream against a hand-computed expected stream.

// File: rtl/rmf_pkg.sv
package rmf_pkg;

   localparam logic [7:0] COMMA_VAL = 8'hBC;
   localparam logic [7:0] SKIP_VAL  = 8'hFD;

   typedef struct packed {
      logic       k;
      logic [7:0] v;
   } rmf_char_t;

   function automatic logic is_comma(rmf_char_t c);
      return c.k && (c.v == COMMA_VAL);
   endfunction

   function automatic logic is_skip(rmf_char_t c);
      return c.k && (c.v == SKIP_VAL);
   endfunction

endpackage

// File: rtl/rmf_sync.sv
module rmf_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rmf_store.sv
module rmf_store import rmf_pkg::*; #(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  rmf_char_t     wdata,
   input  logic [AW-1:0] raddr,
   output rmf_char_t     rdata
);

   rmf_char_t cells [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/rmf_wr_ctrl.sv
module rmf_wr_ctrl import rmf_pkg::*; #(
   parameter int DEPTH   = 16,
   parameter int HI_MARK = 12,
   parameter int STAGES  = 2,
   localparam int AW     = $clog2(DEPTH),
   localparam int PW     = AW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  rmf_char_t     in_char,
   input  logic [PW-1:0] rgray_async,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [PW-1:0] wgray,
   output logic [PW-1:0] wbin,
   output logic          full
);

   logic [PW-1:0] rq_gray, rq_bin, occ, wnext;
   logic          in_clu, kept, dropped, drop_skip;

   rmf_sync #(.W(PW), .STAGES(STAGES)) u_rsync (
      .clk(clk), .rst(rst), .d(rgray_async), .q(rq_gray)
   );

   for (genvar i = 0; i < PW; i++) begin : g_g2b
      assign rq_bin[i] = ^rq_gray[PW-1:i];
   end

   assign occ       = wbin - rq_bin;
   assign full      = (occ == PW'(DEPTH));
   assign drop_skip = in_valid && is_skip(in_char) && in_clu && kept && !dropped
                      && (occ > PW'(HI_MARK));
   assign we        = in_valid && !full && !drop_skip;
   assign wnext     = wbin + PW'(1);
   assign waddr     = wbin[AW-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         wbin    <= '0;
         wgray   <= '0;
         in_clu  <= 1'b0;
         kept    <= 1'b0;
         dropped <= 1'b0;
      end else begin
         if (we) begin
            wbin  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
         end
         if (in_valid) begin
            if (is_comma(in_char)) begin
               in_clu  <= 1'b1;
               kept    <= 1'b0;
               dropped <= 1'b0;
            end else if (is_skip(in_char)) begin
               if (drop_skip)       dropped <= 1'b1;
               else if (we && in_clu) kept  <= 1'b1;
            end else begin
               in_clu <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/rmf_rd_ctrl.sv
module rmf_rd_ctrl import rmf_pkg::*; #(
   parameter int DEPTH   = 16,
   parameter int LO_MARK = 4,
   parameter int STAGES  = 2,
   localparam int AW     = $clog2(DEPTH),
   localparam int PW     = AW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          rd_en,
   input  logic [PW-1:0] wgray_async,
   input  rmf_char_t     head,
   output logic [AW-1:0] raddr,
   output logic [PW-1:0] rgray,
   output logic [PW-1:0] rbin,
   output logic          out_valid,
   output rmf_char_t     out_char,
   output logic          empty
);

   logic [PW-1:0] wq_gray, wq_bin, occ, rnext;
   logic          in_clu, ins_done, take, hold;

   rmf_sync #(.W(PW), .STAGES(STAGES)) u_wsync (
      .clk(clk), .rst(rst), .d(wgray_async), .q(wq_gray)
   );

   for (genvar i = 0; i < PW; i++) begin : g_g2b
      assign wq_bin[i] = ^wq_gray[PW-1:i];
   end

   assign occ   = wq_bin - rbin;
   assign empty = (occ == '0);
   assign take  = rd_en && !empty;
   assign hold  = take && is_skip(head) && in_clu && !ins_done && (occ < PW'(LO_MARK));
   assign rnext = rbin + PW'(1);
   assign raddr = rbin[AW-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         rbin      <= '0;
         rgray     <= '0;
         in_clu    <= 1'b0;
         ins_done  <= 1'b0;
         out_valid <= 1'b0;
         out_char  <= '0;
      end else begin
         out_valid <= take;
         if (take) begin
            out_char <= head;
            if (hold) begin
               ins_done <= 1'b1;
            end else begin
               rbin  <= rnext;
               rgray <= rnext ^ (rnext >> 1);
            end
            if (is_comma(head)) begin
               in_clu   <= 1'b1;
               ins_done <= 1'b0;
            end else if (!is_skip(head)) begin
               in_clu <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/skip_rate_fifo.sv
module skip_rate_fifo import rmf_pkg::*; #(
   parameter int DEPTH       = 16,
   parameter int LO_MARK     = DEPTH / 4,
   parameter int HI_MARK     = (3 * DEPTH) / 4,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(DEPTH),
   localparam int PW         = AW + 1
) (
   input  logic       wr_clk,
   input  logic       wr_rst,
   input  logic       wr_valid,
   input  logic       wr_ctrl,
   input  logic [7:0] wr_data,
   output logic       full,
   input  logic       rd_clk,
   input  logic       rd_rst,
   input  logic       rd_en,
   output logic       rd_valid,
   output logic       rd_ctrl,
   output logic [7:0] rd_data,
   output logic       empty
);

   if ((DEPTH < 4) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("skip_rate_fifo: DEPTH must be a power of two of at least 4");
   end
   if ((LO_MARK < 1) || (LO_MARK >= HI_MARK) || (HI_MARK >= DEPTH)) begin : g_bad_marks
      $error("skip_rate_fifo: need 1 <= LO_MARK < HI_MARK < DEPTH");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("skip_rate_fifo: SYNC_STAGES must be at least 2");
   end

   rmf_char_t     wchar, head, ochar;
   logic          we;
   logic [AW-1:0] waddr, raddr;
   logic [PW-1:0] wgray, rgray, wptr_bin, rptr_bin;

   assign wchar = {wr_ctrl, wr_data};

   rmf_wr_ctrl #(.DEPTH(DEPTH), .HI_MARK(HI_MARK), .STAGES(SYNC_STAGES)) u_wr (
      .clk(wr_clk), .rst(wr_rst), .in_valid(wr_valid), .in_char(wchar),
      .rgray_async(rgray), .we(we), .waddr(waddr), .wgray(wgray),
      .wbin(wptr_bin), .full(full)
   );

   rmf_store #(.DEPTH(DEPTH)) u_mem (
      .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wchar),
      .raddr(raddr), .rdata(head)
   );

   rmf_rd_ctrl #(.DEPTH(DEPTH), .LO_MARK(LO_MARK), .STAGES(SYNC_STAGES)) u_rd (
      .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en), .wgray_async(wgray),
      .head(head), .raddr(raddr), .rgray(rgray), .rbin(rptr_bin),
      .out_valid(rd_valid), .out_char(ochar), .empty(empty)
   );

   assign rd_ctrl = ochar.k;
   assign rd_data = ochar.v;

endmodule

// File: rtl/skip_rate_fifo_chk.sv
module skip_rate_fifo_chk #(
   parameter int PW = 5
) (
   input logic          wr_clk,
   input logic          wr_rst,
   input logic          rd_clk,
   input logic          rd_rst,
   input logic          full,
   input logic          empty,
   input logic          rd_en,
   input logic          rd_valid,
   input logic          rd_ctrl,
   input logic [7:0]    rd_data,
   input logic [PW-1:0] wptr,
   input logic [PW-1:0] rptr
);

   // R6
   no_overflow_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
      full |=> (wptr == $past(wptr)));

   // R6
   wptr_step_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
      (wptr == $past(wptr)) || (wptr == $past(wptr) + PW'(1)));

   // R2
   rptr_step_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
      (rptr == $past(rptr)) || (rptr == $past(rptr) + PW'(1)));

   // R7
   empty_hold_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
      (empty || !rd_en) |=> (!rd_valid && $stable(rd_data) && $stable(rd_ctrl)
                             && (rptr == $past(rptr))));

   // R5
   no_replay_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
      (rd_valid && !(rd_ctrl && (rd_data == 8'hFD))) |-> (rptr == $past(rptr) + PW'(1)));

endmodule

bind skip_rate_fifo skip_rate_fifo_chk #(.PW(PW)) u_chk (
   .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
   .full(full), .empty(empty), .rd_en(rd_en), .rd_valid(rd_valid),
   .rd_ctrl(rd_ctrl), .rd_data(rd_data), .wptr(wptr_bin), .rptr(rptr_bin)
);

// File: tb/skip_rate_fifo_test.sv
module skip_rate_fifo_test;

   logic       wr_clk = 1'b0, rd_clk = 1'b0;
   logic       wr_rst = 1'b1, rd_rst = 1'b1;
   logic       wr_valid = 1'b0, wr_ctrl = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_en = 1'b0;
   logic       full, empty, rd_valid, rd_ctrl;
   logic [7:0] rd_data;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;
   logic [8:0] exp_q [0:31];
   logic [8:0] got_q [0:31];
   int exp_n = 0, got_n = 0;

   // read clock: 8 ns period (125 MHz); write clock slightly slower
   always #4 rd_clk = ~rd_clk;
   always #5 wr_clk = ~wr_clk;

   skip_rate_fifo uut (
      .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_ctrl(wr_ctrl),
      .wr_data(wr_data), .full(full), .rd_clk(rd_clk), .rd_rst(rd_rst),
      .rd_en(rd_en), .rd_valid(rd_valid), .rd_ctrl(rd_ctrl), .rd_data(rd_data),
      .empty(empty)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic put(logic k, logic [7:0] v);
      @(negedge wr_clk);
      wr_valid = 1'b1; wr_ctrl = k; wr_data = v;
   endtask

   task automatic put_end();
      @(negedge wr_clk);
      wr_valid = 1'b0;
   endtask

   task automatic settle();
      repeat (12) @(negedge rd_clk);
   endtask

   task automatic want(logic k, logic [7:0] v);
      exp_q[exp_n] = {k, v};
      exp_n++;
   endtask

   task automatic drain(int cycles);
      got_n = 0;
      @(negedge rd_clk);
      rd_en = 1'b1;
      for (int i = 0; i < cycles; i++) begin
         @(negedge rd_clk);
         if (rd_valid && got_n < 32) begin
            got_q[got_n] = {rd_ctrl, rd_data};
            got_n++;
         end
      end
      rd_en = 1'b0;
   endtask

   task automatic compare(string req);
      check({req, " length"}, got_n, exp_n);
      for (int i = 0; i < exp_n; i++) check(req, int'(got_q[i]), int'(exp_q[i]));
   endtask

   task automatic t_reset();
      repeat (4) @(negedge rd_clk);
      check("R8 empty", int'(empty), 1);
      check("R8 full", int'(full), 0);
      check("R8 rd_valid", int'(rd_valid), 0);
      @(negedge rd_clk); rd_rst = 1'b0;
      @(negedge wr_clk); wr_rst = 1'b0;
      settle();
   endtask

   // R5 R1: data, a lone skip and a lone comma pass untouched
   task automatic t_passthru();
      exp_n = 0;
      put(1'b0, 8'h01); want(1'b0, 8'h01);
      put(1'b1, 8'hFD); want(1'b1, 8'hFD);
      put(1'b0, 8'h02); want(1'b0, 8'h02);
      put(1'b1, 8'hBC); want(1'b1, 8'hBC);
      put(1'b0, 8'h03); want(1'b0, 8'h03);
      put_end(); settle();
      drain(20);
      compare("R5 R1 stream");
      // R7: request while empty
      @(negedge rd_clk); rd_en = 1'b1;
      repeat (3) @(negedge rd_clk);
      check("R7 rd_valid", int'(rd_valid), 0);
      check("R7 held data", int'(rd_data), 8'h03);
      check("R7 empty", int'(empty), 1);
      rd_en = 1'b0;
   endtask

   // R2 R3: one skip added per cluster at low occupancy
   task automatic t_insert();
      exp_n = 0;
      put(1'b1, 8'hBC); want(1'b1, 8'hBC);
      for (int i = 0; i < 3; i++) put(1'b1, 8'hFD);
      for (int i = 0; i < 4; i++) want(1'b1, 8'hFD);
      put_end(); settle();
      drain(20);
      compare("R2 first cluster");
      exp_n = 0;
      put(1'b1, 8'hBC); want(1'b1, 8'hBC);
      for (int i = 0; i < 2; i++) put(1'b1, 8'hFD);
      for (int i = 0; i < 3; i++) want(1'b1, 8'hFD);
      put_end(); settle();
      drain(20);
      compare("R3 second cluster");
   endtask

   // R9: occupancy between marks leaves a cluster intact
   task automatic t_middle();
      exp_n = 0;
      put(1'b1, 8'hBC); want(1'b1, 8'hBC);
      for (int i = 0; i < 5; i++) begin put(1'b1, 8'hFD); want(1'b1, 8'hFD); end
      for (int i = 0; i < 6; i++) begin
         put(1'b0, 8'h40 + 8'(i)); want(1'b0, 8'h40 + 8'(i));
      end
      put_end(); settle();
      drain(30);
      compare("R9 stream");
   endtask

   // R4 R6: one skip dropped at high occupancy, write dropped when full
   task automatic t_delete();
      exp_n = 0;
      put(1'b1, 8'hBC); want(1'b1, 8'hBC);
      for (int i = 0; i < 13; i++) put(1'b1, 8'hFD);
      for (int i = 0; i < 12; i++) want(1'b1, 8'hFD);
      for (int i = 0; i < 3; i++) begin
         put(1'b0, 8'h10 + 8'(i)); want(1'b0, 8'h10 + 8'(i));
      end
      put(1'b0, 8'h77);
      put_end();
      check("R6 full", int'(full), 1);
      settle();
      drain(30);
      compare("R4 R6 stream");
      settle();
      check("R6 full cleared", int'(full), 0);
      check("R7 empty after drain", int'(empty), 1);
   endtask

   initial begin
      t_reset();
      t_passthru();
      t_insert();
      t_middle();
      t_delete();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(negedge rd_clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule